// File: doc/BRIEF.md
# Bus Debug Trigger Unit

This block sits beside a processor bus and inspects every bus cycle: a 16-bit address, an 8-bit data byte, a read/write flag and a valid strobe. Two 16-bit comparator values, A and B, and a 4-bit mode word decide what counts as a trigger. The modes cover single address matches, an ordered A-before-B sequence, same-cycle address-plus-data matches, inclusive and exclusive address ranges, and capture modes. In a capture mode each qualifying cycle writes the bus data byte into an eight-entry FIFO. The run stops when that FIFO fills.

Software or a debug host pulses `arm` to begin a run. The block then raises a one-cycle `trig_pulse` for each qualifying bus cycle. It can also turn a trigger into a breakpoint request of tag type or force type. The host reads captured bytes through a pop/count port once the run has stopped. Every output is registered, so a qualifying bus cycle at clock edge k shows up on the outputs right after edge k.

Top module: `bus_trig_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `trig_pulse`, `brk_tag_req`, `brk_force_req`, `run_active` and `fifo_count` are all 0.
- R2: A cycle with `arm` high sets `run_active` at that edge, empties the FIFO, clears the record of an earlier A match and forces every request output to 0 for that cycle.
- R3: A bus cycle is evaluated only when `bus_valid` is high, `run_active` is high and `arm` is low. Any other cycle raises no trigger, no request, no capture and no A-seen record.
- R4: Mode 0: a trigger occurs when the address equals A.
- R5: Mode 1: a trigger occurs when the address equals A or equals B.
- R6: Mode 2: a B address match triggers only if an A address match happened in an earlier evaluated cycle of the same run. An A and a B match in the same cycle does not trigger.
- R7: Mode 3 triggers when the address equals A, the data equals bits 7:0 of B and R/W qualifies, all in one cycle. Mode 4 is the same except that the data must differ from bits 7:0 of B. Bits 15:8 of B are ignored. R/W qualifies when `rw_qual_en` is 0, or when `bus_rw` equals `rw_qual_val`.
- R8: With `brk_en` high and `brk_is_tag` low, `brk_force_req` copies the trigger. With `brk_is_tag` high, `brk_tag_req` copies the trigger, except in modes 3 and 4, where it fires on an A address match with R/W qualified and ignores the data. With `brk_en` low, neither request is raised.
- R9: Capture modes: mode 5 triggers on every B address match. Mode 6 triggers on every B address match after an earlier A match. Mode 9 triggers on every A address match. Each such trigger pushes `bus_data` into the FIFO, and the FIFO is read oldest first.
- R10: When a capture brings `fifo_count` to 8, `run_active` drops at that edge. From then on no trigger or request appears until the next `arm`.
- R11: Mode 7 triggers when A <= address <= B, both bounds inclusive. Mode 8 triggers when address < A or address > B.
- R12: `fifo_pop` removes the oldest entry when `fifo_count` is non-zero and does nothing when the FIFO is empty. `fifo_rdata` shows the oldest entry.
- R13: Mode values 10 to 15 never trigger, request or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start (or restart) a run |
| mode | input | 4 | Trigger mode, 0 to 9 valid |
| cmp_a | input | 16 | Comparator A value |
| cmp_b | input | 16 | Comparator B value (low byte doubles as data value) |
| rw_qual_en | input | 1 | Enable R/W qualification in modes 3 and 4 |
| rw_qual_val | input | 1 | Required R/W level when qualification is on |
| brk_en | input | 1 | Enable breakpoint requests |
| brk_is_tag | input | 1 | 1 selects tag-type, 0 force-type request |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus data byte |
| bus_rw | input | 1 | Bus read/write flag |
| fifo_pop | input | 1 | Remove oldest captured byte |
| trig_pulse | output | 1 | One-cycle trigger indication |
| brk_tag_req | output | 1 | Tag-type breakpoint request |
| brk_force_req | output | 1 | Force-type breakpoint request |
| run_active | output | 1 | A run is in progress |
| fifo_rdata | output | 8 | Oldest captured byte |
| fifo_count | output | 4 | Number of captured bytes |

## Verification
A stale A-seen flag shows up as a mode 2 or mode 6 trigger on the first B match after `arm`, exactly one cycle after that bus cycle. A wrong FIFO pointer or count shows up at once in `fifo_count`, or in the first popped byte. A missed full condition leaves `run_active` high one cycle after the eighth capture and lets a ninth trigger through. The bench keeps its own model of the trigger, the requests, the run flag and a byte queue, and compares every output after each edge. Each of these faults therefore surfaces in the first cycle it affects.

// File: rtl/bus_trig_pkg.sv
// Package: shared mode encoding for the bus debug trigger unit.
// Assumes: mode values above 9 are reserved and produce no activity.
package bus_trig_pkg;

    typedef enum logic [3:0] {
        TM_A_ONLY      = 4'd0,
        TM_A_OR_B      = 4'd1,
        TM_A_THEN_B    = 4'd2,
        TM_FULL_EQ     = 4'd3,
        TM_FULL_NE     = 4'd4,
        TM_CAP_B       = 4'd5,
        TM_A_THEN_CAPB = 4'd6,
        TM_INSIDE      = 4'd7,
        TM_OUTSIDE     = 4'd8,
        TM_CAP_A       = 4'd9
    } trig_mode_e;

endpackage

// File: rtl/bus_trig_match.sv
// Module: combinational match logic. From one bus cycle, the comparators and the
// A-seen flag it decides hit, tag hit and whether the hit is a capture.
// Assumes: 'act' already folds in valid, run and arm gating.
module bus_trig_match
    import bus_trig_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [3:0]    mode,
    input  logic          act,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          rw,
    input  logic [AW-1:0] cmp_a,
    input  logic [AW-1:0] cmp_b,
    input  logic          rw_en,
    input  logic          rw_val,
    input  logic          a_seen,
    output logic          a_hit,
    output logic          hit,
    output logic          tag_hit,
    output logic          is_capture
);

    logic a_eq, b_eq, d_eq, rw_ok, ge_a, le_b;
    trig_mode_e m;

    // Elementary comparisons, qualified by the active cycle.
    always_comb begin
        m     = trig_mode_e'(mode);
        a_eq  = act && (addr == cmp_a);
        b_eq  = act && (addr == cmp_b);
        d_eq  = (data == cmp_b[DW-1:0]);
        rw_ok = !rw_en || (rw == rw_val);
        ge_a  = (addr >= cmp_a);
        le_b  = (addr <= cmp_b);
        a_hit = a_eq;
    end

    // Mode decoder: trigger, tag and capture selection.
    always_comb begin
        hit        = 1'b0;
        tag_hit    = 1'b0;
        is_capture = 1'b0;
        case (m)
            TM_A_ONLY:      hit = a_eq;
            TM_A_OR_B:      hit = a_eq || b_eq;
            TM_A_THEN_B:    hit = b_eq && a_seen;
            TM_FULL_EQ:     hit = a_eq && rw_ok && d_eq;
            TM_FULL_NE:     hit = a_eq && rw_ok && !d_eq;
            TM_CAP_B:       begin hit = b_eq;           is_capture = 1'b1; end
            TM_A_THEN_CAPB: begin hit = b_eq && a_seen; is_capture = 1'b1; end
            TM_INSIDE:      hit = act && ge_a && le_b;
            TM_OUTSIDE:     hit = act && (!ge_a || !le_b);
            TM_CAP_A:       begin hit = a_eq;           is_capture = 1'b1; end
            default:        hit = 1'b0;
        endcase
        if (m == TM_FULL_EQ || m == TM_FULL_NE) tag_hit = a_eq && rw_ok;
        else                                    tag_hit = hit;
    end

endmodule

// File: rtl/bus_trig_fifo.sv
// Module: capture FIFO. It flags the push that fills it so the run can end.
// Assumes: DEPTH is a power of two; clear takes priority over push and pop.
module bus_trig_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          fill_now
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    // Accept qualifiers: no push into a full FIFO, no pop from an empty one.
    always_comb begin
        push_ok  = push && !clr && (count != FULL_CNT);
        pop_ok   = pop && !clr && (count != '0);
        fill_now = push_ok && !pop_ok && (count == LAST_CNT);
        rdata    = mem[rd_ptr];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (!push_ok && pop_ok) count <= count - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/bus_trig_seq.sv
// Module: run sequencer. Holds the run flag and the A-seen record.
// Assumes: arm has priority over the end-of-run condition.
module bus_trig_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic a_hit,
    input  logic fill_now,
    output logic run_active,
    output logic a_seen
);

    // Run flag: set by arm, cleared when a capture fills the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_active <= 1'b0;
        else if (arm)      run_active <= 1'b1;
        else if (fill_now) run_active <= 1'b0;
    end

    // A-seen record: sticky within a run, cleared by arm.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) a_seen <= 1'b0;
        else if (a_hit)    a_seen <= 1'b1;
    end

endmodule

// File: rtl/bus_trig_unit.sv
// Module: top of the bus debug trigger unit. Gates bus cycles with run state,
// routes captures into the FIFO and registers the trigger and request outputs.
// Assumes: all inputs are synchronous to clk.
module bus_trig_unit #(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] cmp_a,
    input  logic [AW-1:0] cmp_b,
    input  logic          rw_qual_en,
    input  logic          rw_qual_val,
    input  logic          brk_en,
    input  logic          brk_is_tag,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_rw,
    input  logic          fifo_pop,
    output logic          trig_pulse,
    output logic          brk_tag_req,
    output logic          brk_force_req,
    output logic          run_active,
    output logic [DW-1:0] fifo_rdata,
    output logic [CW-1:0] fifo_count
);

    logic act, a_seen, a_hit, hit, tag_hit, is_capture, fill_now;

    // Evaluate a bus cycle only inside a run and not on an arm cycle.
    always_comb act = bus_valid && run_active && !arm;

    bus_trig_match #(.AW(AW), .DW(DW)) match_i (
        .mode(mode), .act(act), .addr(bus_addr), .data(bus_data), .rw(bus_rw),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .rw_en(rw_qual_en), .rw_val(rw_qual_val),
        .a_seen(a_seen), .a_hit(a_hit), .hit(hit), .tag_hit(tag_hit),
        .is_capture(is_capture)
    );

    bus_trig_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(arm), .push(hit && is_capture),
        .wdata(bus_data), .pop(fifo_pop), .rdata(fifo_rdata),
        .count(fifo_count), .fill_now(fill_now)
    );

    bus_trig_seq seq_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .a_hit(a_hit),
        .fill_now(fill_now), .run_active(run_active), .a_seen(a_seen)
    );

    // Registered trigger and breakpoint request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            trig_pulse    <= 1'b0;
            brk_tag_req   <= 1'b0;
            brk_force_req <= 1'b0;
        end else begin
            trig_pulse    <= hit;
            brk_tag_req   <= brk_en && brk_is_tag && tag_hit;
            brk_force_req <= brk_en && !brk_is_tag && hit;
        end
    end

endmodule

// File: rtl/bus_trig_chk.sv
// Module: assertion checker for bus_trig_unit, attached by bind.
// Assumes: port names match the top module.
module bus_trig_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic [3:0]    mode,
    input logic          bus_valid,
    input logic          brk_en,
    input logic          fifo_pop,
    input logic          trig_pulse,
    input logic          brk_tag_req,
    input logic          brk_force_req,
    input logic          run_active,
    input logic [CW-1:0] fifo_count
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));                                              // R12
    AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (run_active && fifo_count == '0 && !trig_pulse));               // R2
    AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(bus_valid) && $past(run_active) && !$past(arm))); // R3
    AST_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CW'(DEPTH)) |-> !run_active);                            // R10
    AST_ONE_REQ_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_tag_req && brk_force_req));                                       // R8
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_tag_req || brk_force_req) |-> $past(brk_en));                      // R8
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(mode) <= 4'd9));                                  // R13
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && fifo_pop && !arm && !trig_pulse)
            |=> (fifo_count <= CW'(1)));                                        // R12

endmodule

bind bus_trig_unit bus_trig_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .bus_valid(bus_valid),
    .brk_en(brk_en), .fifo_pop(fifo_pop), .trig_pulse(trig_pulse),
    .brk_tag_req(brk_tag_req), .brk_force_req(brk_force_req),
    .run_active(run_active), .fifo_count(fifo_count)
);

// File: tb/bus_trig_unit_tb.sv
`timescale 1ns/1ps
module bus_trig_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] cmp_a = '0, cmp_b = '0;
    logic        rw_qual_en = 1'b0, rw_qual_val = 1'b0;
    logic        brk_en = 1'b0, brk_is_tag = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_rw = 1'b0;
    logic        fifo_pop = 1'b0;
    logic        trig_pulse, brk_tag_req, brk_force_req, run_active;
    logic [7:0]  fifo_rdata;
    logic [3:0]  fifo_count;

    always #2.5 clk = ~clk;

    bus_trig_unit dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .rw_qual_en(rw_qual_en), .rw_qual_val(rw_qual_val),
        .brk_en(brk_en), .brk_is_tag(brk_is_tag), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_rw(bus_rw),
        .fifo_pop(fifo_pop), .trig_pulse(trig_pulse), .brk_tag_req(brk_tag_req),
        .brk_force_req(brk_force_req), .run_active(run_active),
        .fifo_rdata(fifo_rdata), .fifo_count(fifo_count)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    bit       m_run, m_seen, m_trig, m_tag, m_force;
    byte unsigned q[$];

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit act, am, bm, rwok, dm, hit, th, cap, full_mode;
        if (!rst_n || arm) begin
            m_run = arm && rst_n; m_seen = 0; q.delete();
            m_trig = 0; m_tag = 0; m_force = 0;
            return;
        end
        act  = bus_valid && m_run;
        am   = act && (bus_addr == cmp_a);
        bm   = act && (bus_addr == cmp_b);
        rwok = !rw_qual_en || (bus_rw == rw_qual_val);
        dm   = (bus_data == cmp_b[7:0]);
        hit = 0; cap = 0; full_mode = 0; th = 0;
        case (int'(mode))
            0: hit = am;
            1: hit = am || bm;
            2: hit = bm && m_seen;
            3: begin hit = am && rwok && dm;  full_mode = 1; end
            4: begin hit = am && rwok && !dm; full_mode = 1; end
            5: begin hit = bm; cap = 1; end
            6: begin hit = bm && m_seen; cap = 1; end
            7: hit = act && (int'(bus_addr) >= int'(cmp_a)) && (int'(bus_addr) <= int'(cmp_b));
            8: hit = act && ((int'(bus_addr) < int'(cmp_a)) || (int'(bus_addr) > int'(cmp_b)));
            9: begin hit = am; cap = 1; end
            default: hit = 0;
        endcase
        th = full_mode ? (am && rwok) : hit;
        if (am) m_seen = 1;
        if (fifo_pop && q.size() > 0) void'(q.pop_front());
        if (cap && hit && q.size() < 8) q.push_back(bus_data);
        if (cap && hit && q.size() == 8) m_run = 0;
        m_trig  = hit;
        m_tag   = brk_en && brk_is_tag && th;
        m_force = brk_en && !brk_is_tag && hit;
    endtask

    task automatic compare_all();
        chk("trig_pulse", int'(trig_pulse), int'(m_trig));
        chk("brk_tag_req", int'(brk_tag_req), int'(m_tag));
        chk("brk_force_req", int'(brk_force_req), int'(m_force));
        chk("run_active", int'(run_active), int'(m_run));
        chk("fifo_count", int'(fifo_count), q.size());
        if (q.size() > 0) chk("fifo_rdata", int'(fifo_rdata), int'(q[0]));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus(bit v, logic [15:0] a, logic [7:0] d, bit rw);
        bus_valid = v; bus_addr = a; bus_data = d; bus_rw = rw;
        tick();
        bus_valid = 0;
    endtask

    task automatic do_arm();
        arm = 1; tick(); arm = 0;
    endtask

    task automatic cfg(int md, logic [15:0] a, logic [15:0] b, bit re, bit rv, bit be, bit bt);
        mode = 4'(md); cmp_a = a; cmp_b = b; rw_qual_en = re; rw_qual_val = rv;
        brk_en = be; brk_is_tag = bt;
        do_arm();
    endtask

    function automatic string req_of(int md);
        case (md)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3, 4: return "R7";
            5, 6, 9: return "R9";
            7, 8: return "R11";
            default: return "R13";
        endcase
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        repeat (3) tick();
        chk("reset trig", int'(trig_pulse), 0);
        chk("reset run", int'(run_active), 0);
        chk("reset count", int'(fifo_count), 0);
        rst_n = 1;
        tick();

        // R3: no run yet, matching address must be ignored
        cur_req = "R3";
        mode = 0; cmp_a = 16'h1234;
        bus(1, 16'h1234, 8'h00, 0);
        chk("unarmed trig", int'(trig_pulse), 0);

        // R4 A only; R2 arm start
        cur_req = "R2";
        cfg(0, 16'h1234, 16'h5678, 0, 0, 1, 0);
        chk("armed run", int'(run_active), 1);
        cur_req = "R4";
        bus(1, 16'h1234, 8'h11, 0);
        chk("A match trig", int'(trig_pulse), 1);
        bus(1, 16'h1235, 8'h11, 0);
        cur_req = "R3";
        bus(0, 16'h1234, 8'h11, 0);
        chk("invalid cycle trig", int'(trig_pulse), 0);

        // R5 A or B
        cur_req = "R5";
        cfg(1, 16'h0100, 16'h0200, 0, 0, 0, 0);
        bus(1, 16'h0200, 8'h00, 1);
        chk("B match trig", int'(trig_pulse), 1);
        bus(1, 16'h0100, 8'h00, 1);
        bus(1, 16'h0300, 8'h00, 1);

        // R6 A then B, including same-cycle A and B
        cur_req = "R6";
        cfg(2, 16'h4000, 16'h4000, 0, 0, 1, 1);
        bus(1, 16'h4000, 8'h00, 0);
        chk("same-cycle A/B trig", int'(trig_pulse), 0);
        bus(1, 16'h4000, 8'h00, 0);
        chk("second cycle trig", int'(trig_pulse), 1);
        cfg(2, 16'h4000, 16'h5000, 0, 0, 0, 0);
        bus(1, 16'h5000, 8'h00, 0);
        bus(1, 16'h4000, 8'h00, 0);
        repeat (5) bus(1, 16'h0000, 8'h00, 0);
        bus(1, 16'h5000, 8'h00, 0);
        chk("B after gap trig", int'(trig_pulse), 1);

        // R7 full modes, R8 tag ignores data
        cur_req = "R7";
        cfg(3, 16'h2222, 16'hAB5A, 1, 1, 1, 0);
        bus(1, 16'h2222, 8'h5A, 1);
        chk("full eq trig", int'(trig_pulse), 1);
        bus(1, 16'h2222, 8'h5A, 0);
        chk("rw mismatch trig", int'(trig_pulse), 0);
        bus(1, 16'h2222, 8'hAB, 1);
        cfg(4, 16'h2222, 16'h005A, 0, 0, 1, 1);
        bus(1, 16'h2222, 8'h5B, 0);
        bus(1, 16'h2222, 8'h5A, 1);
        cur_req = "R8";
        chk("tag on A only", int'(brk_tag_req), 1);
        chk("no trig on data eq", int'(trig_pulse), 0);
        cfg(0, 16'h2222, 16'h0, 0, 0, 0, 1);
        bus(1, 16'h2222, 8'h00, 0);
        chk("brk disabled", int'(brk_tag_req), 0);

        // R9 capture, R10 run end on full, R12 pop
        cur_req = "R9";
        cfg(5, 16'h0000, 16'h3000, 0, 0, 1, 0);
        for (int i = 0; i < 8; i++) begin
            bus(1, 16'h3000, 8'(8'hA0 + i), 0);
            bus(1, 16'h3001, 8'hFF, 0);
        end
        cur_req = "R10";
        chk("full count", int'(fifo_count), 8);
        chk("run ended", int'(run_active), 0);
        bus(1, 16'h3000, 8'h77, 0);
        chk("no trig after end", int'(trig_pulse), 0);
        cur_req = "R12";
        chk("oldest byte", int'(fifo_rdata), 8'hA0);
        for (int i = 0; i < 9; i++) begin
            fifo_pop = 1; tick(); fifo_pop = 0;
        end
        chk("empty after pops", int'(fifo_count), 0);
        fifo_pop = 1; tick(); fifo_pop = 0;
        chk("pop on empty", int'(fifo_count), 0);

        cur_req = "R9";
        cfg(6, 16'h0010, 16'h0020, 0, 0, 0, 0);
        bus(1, 16'h0020, 8'h01, 0);
        bus(1, 16'h0010, 8'h02, 0);
        bus(1, 16'h0020, 8'h03, 0);
        bus(1, 16'h0020, 8'h04, 0);
        chk("A-then-capture count", int'(fifo_count), 2);
        cfg(9, 16'h0010, 16'h0020, 0, 0, 0, 0);
        bus(1, 16'h0010, 8'h55, 0);
        cur_req = "R2";
        do_arm();
        chk("arm clears fifo", int'(fifo_count), 0);

        // R11 ranges at the bounds
        cur_req = "R11";
        cfg(7, 16'h1000, 16'h1FFF, 0, 0, 0, 0);
        bus(1, 16'h1000, 0, 0); chk("inside low bound", int'(trig_pulse), 1);
        bus(1, 16'h1FFF, 0, 0); chk("inside high bound", int'(trig_pulse), 1);
        bus(1, 16'h0FFF, 0, 0); chk("below range", int'(trig_pulse), 0);
        cfg(8, 16'h1000, 16'h1FFF, 0, 0, 0, 0);
        bus(1, 16'h0FFF, 0, 0); chk("outside low", int'(trig_pulse), 1);
        bus(1, 16'h2000, 0, 0); chk("outside high", int'(trig_pulse), 1);
        bus(1, 16'h1000, 0, 0); chk("outside at bound", int'(trig_pulse), 0);

        // R13 reserved modes
        cur_req = "R13";
        cfg(12, 16'h1000, 16'h1000, 0, 0, 1, 0);
        bus(1, 16'h1000, 0, 0);
        chk("reserved trig", int'(trig_pulse), 0);

        // Mixed traffic across modes, compared every cycle against the model
        for (int blk = 0; blk < 30; blk++) begin
            int md = $urandom_range(0, 12);
            logic [15:0] a = 16'($urandom_range(0, 16'hFFF0));
            logic [15:0] b = a + 16'($urandom_range(0, 8));
            cur_req = req_of(md);
            cfg(md, a, b, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1);
            for (int c = 0; c < 60; c++) begin
                int pick = $urandom_range(0, 4);
                logic [15:0] ad;
                case (pick)
                    0: ad = a;
                    1: ad = b;
                    2: ad = a - 16'd1;
                    3: ad = b + 16'd1;
                    default: ad = 16'($urandom);
                endcase
                fifo_pop = ($urandom_range(0, 5) == 0);
                bus($urandom_range(0, 3) != 0, ad,
                    ($urandom_range(0, 1) == 1) ? b[7:0] : 8'($urandom),
                    $urandom_range(0, 1) == 1);
                fifo_pop = 0;
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule